// File: doc/BRIEF.md
# Two-Tier Write Protection Controller

This block decides, for a small serial EEPROM-style memory, which control bytes are acknowledged and which array bytes are actually written. A serial front end has already decoded the bus traffic. It passes in each received control byte as a 4-bit class nibble, a 3-bit select field and a read/write bit. It also reports every later byte, every stop condition and every array byte that is ready to commit, together with its target address. The controller answers each control byte with an acknowledge decision. For each array byte it produces either a write enable or a drop indication.

Two software guard flags protect the lower half of the array. The permanent flag can be set but never cleared by any bus command. Its power-up value is reloaded from outside through a load strobe, which stands in for nonvolatile retention. The reversible flag can be both set and cleared. Both commands that change the reversible flag need a separate high-voltage qualifier input. A hardware protect input overrides both flags and guards the whole array. The acknowledge answers also serve as status reads of the flags.

Top module: `wp_guard_ctrl`

## Requirements
- R1: A control byte with class nibble 4'b1010 whose select field equals `pin_addr` is acknowledged for either direction. A 4'b1010 byte with a different select field, or a byte with a class nibble other than 4'b1010 or 4'b0110, is not acknowledged. The `ack_vld`/`ack` answer appears in the cycle after `hdr_valid`.
- R2: While `hw_wp` is 1, no array byte is enabled. A guard command that completes while `hw_wp` is 1 changes neither flag, although it is still acknowledged under the usual rules.
- R3: While `hw_wp` is 0 and either flag is set, commits to addresses 0x00–0x7F are not enabled and commits to 0x80–0xFF are enabled. With both flags clear, every address is enabled.
- R4: Every commit request that is not enabled raises `byte_drop` for one cycle, one cycle after `wr_req`. An enabled commit raises `byte_we` at the same point. The front end therefore still runs the write cycle for a discarded byte.
- R5: A guard-class (4'b0110) write is taken as the permanent-set command when `hv_a0` is 0 and the select field equals `pin_addr`. When that command completes, the permanent flag is set. After that, no 4'b0110 control byte of any kind is acknowledged.
- R6: With `hv_a0` at 1, select 3'b001 with the write bit and `pin_addr[2:1]`=2'b00 sets the reversible flag. Select 3'b011 with the write bit and `pin_addr[2:1]`=2'b01 clears it.
- R7: A status read reuses the set command's control byte with the read bit set. The reversible flag is read with select 3'b001 and `hv_a0`=1. The permanent flag is read with select equal to `pin_addr` and `hv_a0`=0. The answer is an acknowledge when the flag is clear and no acknowledge when it is set.
- R8: Set-reversible is not acknowledged while the reversible flag is set. Clear-reversible is not acknowledged while the permanent flag is set.
- R9: With `hv_a0` at 0, the reversible set and clear control bytes are not acknowledged unless their select field happens to equal `pin_addr`.
- R10: A flag changes only on a `stop_det` pulse that ends an acknowledged guard write which received at least two further bytes (word address and data). A stop after fewer bytes, or a new control byte before the stop, leaves both flags unchanged.
- R11: Reset clears both flags. An `nv_load` pulse copies `nv_perm` into the permanent flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_wp | input | 1 | Hardware protect, guards the whole array |
| pin_addr | input | 3 | Strapped address pin states |
| hv_a0 | input | 1 | High-voltage qualifier on the lowest address pin |
| nv_load | input | 1 | Power-on load strobe for the permanent flag |
| nv_perm | input | 1 | Retained permanent flag value |
| hdr_valid | input | 1 | A control byte has been received |
| hdr_class | input | 4 | Upper nibble of the control byte |
| hdr_sel | input | 3 | Select field of the control byte |
| hdr_rd | input | 1 | Read/write bit of the control byte (1 = read) |
| byte_rx | input | 1 | A byte after the control byte has been received |
| stop_det | input | 1 | A stop condition has been seen |
| wr_req | input | 1 | An array byte is ready to commit |
| wr_addr | input | 8 | Array address of the committing byte |
| ack_vld | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| byte_we | output | 1 | Commit the array byte |
| byte_drop | output | 1 | Byte accepted but discarded |

## Verification
The bench targets the boundary at 0x7F/0x80. A wrong split would either leak a write into the guarded half or block the upper half. It cuts guard commands short and replaces them with a new control byte before the stop. A design that updates flags on the acknowledge, or on the stop alone, would then change state with no complete command. It also issues reversible commands without the high-voltage qualifier, repeats set-reversible, and tries to clear after the permanent flag is set. A decoder that ignores the qualifier or the current flags would acknowledge where it must refuse. Finally, it sends flag commands while `hw_wp` is high. A design that lets hardware protect gate only array writes would change a flag there.

// File: rtl/wp_pkg.sv
// Package: shared command kinds and control-byte codes for the guard controller.
// Assumes the front end splits a control byte into nibble, select field and R/W.
package wp_pkg;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_ARR_RD   = 3'd1,
        CMD_ARR_WR   = 3'd2,
        CMD_SET_PERM = 3'd3,
        CMD_RD_PERM  = 3'd4,
        CMD_SET_REV  = 3'd5,
        CMD_RD_REV   = 3'd6,
        CMD_CLR_REV  = 3'd7
    } cmd_e;

    localparam logic [3:0] CLASS_ARRAY = 4'b1010;
    localparam logic [3:0] CLASS_GUARD = 4'b0110;
    localparam logic [2:0] SEL_REV_SET = 3'b001;
    localparam logic [2:0] SEL_REV_CLR = 3'b011;
    localparam logic [1:0] PINS_REV_SET = 2'b00;
    localparam logic [1:0] PINS_REV_CLR = 2'b01;

    // True for the commands that change a flag when they complete.
    function automatic logic is_flag_write(input cmd_e c);
        return (c == CMD_SET_PERM) || (c == CMD_SET_REV) || (c == CMD_CLR_REV);
    endfunction

endpackage

// File: rtl/wp_hdr_decode.sv
// Module: wp_hdr_decode
// Classifies a control byte into a command kind and decides whether it is
// acknowledged, given the current guard flags and the address pin states.
// Purely combinational; assumes inputs are stable while hdr_valid is high.
module wp_hdr_decode
    import wp_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic [3:0]       hdr_class,
    input  logic [SEL_W-1:0] hdr_sel,
    input  logic             hdr_rd,
    input  logic [SEL_W-1:0] pin_addr,
    input  logic             hv_a0,
    input  logic             perm_q,
    input  logic             rev_q,
    output cmd_e             cmd,
    output logic             ack_ok
);

    logic sel_match;
    logic rev_set_pins;
    logic rev_clr_pins;

    assign sel_match    = (hdr_sel == pin_addr);
    assign rev_set_pins = (pin_addr[SEL_W-1:SEL_W-2] == PINS_REV_SET);
    assign rev_clr_pins = (pin_addr[SEL_W-1:SEL_W-2] == PINS_REV_CLR);

    // Decode the command kind and its acknowledge decision.
    always_comb begin
        cmd    = CMD_NONE;
        ack_ok = 1'b0;
        unique case (hdr_class)
            CLASS_ARRAY: begin
                if (sel_match) begin
                    cmd    = hdr_rd ? CMD_ARR_RD : CMD_ARR_WR;
                    ack_ok = 1'b1;
                end
            end
            CLASS_GUARD: begin
                if (!perm_q) begin
                    if (hv_a0) begin
                        if (hdr_sel == SEL_REV_SET && rev_set_pins) begin
                            cmd    = hdr_rd ? CMD_RD_REV : CMD_SET_REV;
                            ack_ok = !rev_q;
                        end else if (hdr_sel == SEL_REV_CLR && !hdr_rd && rev_clr_pins) begin
                            cmd    = CMD_CLR_REV;
                            ack_ok = 1'b1;
                        end
                    end else if (sel_match) begin
                        cmd    = hdr_rd ? CMD_RD_PERM : CMD_SET_PERM;
                        ack_ok = 1'b1;
                    end
                end
            end
            default: begin
                cmd    = CMD_NONE;
                ack_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wp_flag_bank.sv
// Module: wp_flag_bank
// Holds the permanent and reversible guard flags. Tracks an acknowledged
// guard write, counts the bytes that follow it, and applies the command only
// at a stop that ends a complete command while hardware protect is low.
// Assumes nv_load is pulsed after reset to restore the retained flag.
module wp_flag_bank
    import wp_pkg::*;
#(
    parameter int CMD_BYTES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hdr_valid,
    input  cmd_e hdr_cmd,
    input  logic hdr_ack,
    input  logic byte_rx,
    input  logic stop_det,
    input  logic hw_wp,
    input  logic nv_load,
    input  logic nv_perm,
    output logic perm_q,
    output logic rev_q
);

    localparam int CNT_W = $clog2(CMD_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_BYTES);

    cmd_e             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             commit;

    assign commit = stop_det && is_flag_write(pend_q) && (cnt_q == CNT_FULL) && !hw_wp;

    // Track the pending guard command and the bytes received after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= CMD_NONE;
            cnt_q  <= '0;
        end else if (hdr_valid) begin
            pend_q <= (hdr_ack && is_flag_write(hdr_cmd)) ? hdr_cmd : CMD_NONE;
            cnt_q  <= '0;
        end else if (stop_det) begin
            pend_q <= CMD_NONE;
            cnt_q  <= '0;
        end else if (byte_rx && cnt_q != CNT_FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Permanent flag: loaded at power-up, otherwise only ever set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perm_q <= 1'b0;
        end else if (nv_load) begin
            perm_q <= nv_perm;
        end else if (commit && pend_q == CMD_SET_PERM) begin
            perm_q <= 1'b1;
        end
    end

    // Reversible flag: set or cleared by its completed commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_q <= 1'b0;
        end else if (commit && pend_q == CMD_SET_REV) begin
            rev_q <= 1'b1;
        end else if (commit && pend_q == CMD_CLR_REV) begin
            rev_q <= 1'b0;
        end
    end

endmodule

// File: rtl/wp_write_gate.sv
// Module: wp_write_gate
// Decides per committing byte whether it is written or discarded. The hardware
// input guards every address; either software flag guards the lower half.
// Assumes wr_addr is valid whenever wr_req is high.
module wp_write_gate #(
    parameter int ADDR_W     = 8,
    parameter bit GUARD_HALF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              hw_wp,
    input  logic              perm_q,
    input  logic              rev_q,
    output logic              byte_we,
    output logic              byte_drop
);

    logic in_guarded;
    logic blocked;

    // The guarded region is the lower half, or the whole array if so built.
    generate
        if (GUARD_HALF) begin : g_half
            assign in_guarded = !wr_addr[ADDR_W-1];
        end else begin : g_full
            assign in_guarded = 1'b1;
        end
    endgenerate

    assign blocked = hw_wp || ((perm_q || rev_q) && in_guarded);

    // Register the write or drop decision for the front end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_we   <= 1'b0;
            byte_drop <= 1'b0;
        end else begin
            byte_we   <= wr_req && !blocked;
            byte_drop <= wr_req && blocked;
        end
    end

endmodule

// File: rtl/wp_guard_ctrl.sv
// Module: wp_guard_ctrl (top)
// Combines header decoding, guard flag storage and the array write gate.
// The acknowledge decision is registered and valid one cycle after hdr_valid.
// Assumes the front end pulses each event input for a single cycle.
module wp_guard_ctrl
    import wp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SEL_W     = 3,
    parameter int CMD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_wp,
    input  logic [SEL_W-1:0]  pin_addr,
    input  logic              hv_a0,
    input  logic              nv_load,
    input  logic              nv_perm,
    input  logic              hdr_valid,
    input  logic [3:0]        hdr_class,
    input  logic [SEL_W-1:0]  hdr_sel,
    input  logic              hdr_rd,
    input  logic              byte_rx,
    input  logic              stop_det,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              ack_vld,
    output logic              ack,
    output logic              byte_we,
    output logic              byte_drop
);

    cmd_e dec_cmd;
    logic dec_ack;
    logic perm_q;
    logic rev_q;

    wp_hdr_decode #(.SEL_W(SEL_W)) u_decode (
        .hdr_class (hdr_class),
        .hdr_sel   (hdr_sel),
        .hdr_rd    (hdr_rd),
        .pin_addr  (pin_addr),
        .hv_a0     (hv_a0),
        .perm_q    (perm_q),
        .rev_q     (rev_q),
        .cmd       (dec_cmd),
        .ack_ok    (dec_ack)
    );

    wp_flag_bank #(.CMD_BYTES(CMD_BYTES)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .hdr_cmd   (dec_cmd),
        .hdr_ack   (dec_ack),
        .byte_rx   (byte_rx),
        .stop_det  (stop_det),
        .hw_wp     (hw_wp),
        .nv_load   (nv_load),
        .nv_perm   (nv_perm),
        .perm_q    (perm_q),
        .rev_q     (rev_q)
    );

    wp_write_gate #(.ADDR_W(ADDR_W), .GUARD_HALF(1'b1)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .hw_wp     (hw_wp),
        .perm_q    (perm_q),
        .rev_q     (rev_q),
        .byte_we   (byte_we),
        .byte_drop (byte_drop)
    );

    // Register the acknowledge decision for the serial front end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack     <= 1'b0;
        end else begin
            ack_vld <= hdr_valid;
            ack     <= hdr_valid && dec_ack;
        end
    end

endmodule

// File: rtl/wp_guard_chk.sv
// Module: wp_guard_chk
// Property checks for wp_guard_ctrl, attached with bind below.
module wp_guard_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_wp,
    input logic              nv_load,
    input logic              hdr_valid,
    input logic [3:0]        hdr_class,
    input logic              stop_det,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              ack_vld,
    input logic              ack,
    input logic              byte_we,
    input logic              byte_drop,
    input logic              perm_q,
    input logic              rev_q
);

    AST_ACK_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> ack_vld); // R1

    AST_HW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && hw_wp) |=> (byte_drop && !byte_we)); // R2

    AST_LOW_HALF_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_addr[ADDR_W-1] && (perm_q || rev_q)) |=> !byte_we); // R3

    AST_COMMIT_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (byte_we != byte_drop)); // R4

    AST_PERM_SILENCES_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_class == 4'b0110 && perm_q) |=> !ack); // R5

    AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_q && !nv_load) |=> perm_q); // R5

    AST_REV_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_det |=> $stable(rev_q)); // R10

    AST_FLAGS_FROZEN_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_wp && !nv_load) |=> ($stable(rev_q) && $stable(perm_q))); // R2

endmodule

bind wp_guard_ctrl wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_wp     (hw_wp),
    .nv_load   (nv_load),
    .hdr_valid (hdr_valid),
    .hdr_class (hdr_class),
    .stop_det  (stop_det),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .ack_vld   (ack_vld),
    .ack       (ack),
    .byte_we   (byte_we),
    .byte_drop (byte_drop),
    .perm_q    (perm_q),
    .rev_q     (rev_q)
);

// File: tb/tb_wp_guard_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every clock, plus directed checks.
module tb_wp_guard_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_wp = 1'b0;
    logic [2:0] pin_addr = 3'b000;
    logic       hv_a0 = 1'b0;
    logic       nv_load = 1'b0;
    logic       nv_perm = 1'b0;
    logic       hdr_valid = 1'b0;
    logic [3:0] hdr_class = 4'h0;
    logic [2:0] hdr_sel = 3'b000;
    logic       hdr_rd = 1'b0;
    logic       byte_rx = 1'b0;
    logic       stop_det = 1'b0;
    logic       wr_req = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic       ack_vld, ack, byte_we, byte_drop;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R11";

    always #4 clk = ~clk;

    wp_guard_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hw_wp(hw_wp), .pin_addr(pin_addr), .hv_a0(hv_a0),
        .nv_load(nv_load), .nv_perm(nv_perm), .hdr_valid(hdr_valid),
        .hdr_class(hdr_class), .hdr_sel(hdr_sel), .hdr_rd(hdr_rd),
        .byte_rx(byte_rx), .stop_det(stop_det), .wr_req(wr_req), .wr_addr(wr_addr),
        .ack_vld(ack_vld), .ack(ack), .byte_we(byte_we), .byte_drop(byte_drop)
    );

    // Reference model state: flags, pending command (0 none, 1 perm, 2 set rev, 3 clr rev).
    int m_perm = 0, m_rev = 0, m_pend = 0, m_bytes = 0;
    bit e_ackv = 0, e_ack = 0, e_we = 0, e_drop = 0;

    always @(posedge clk) begin
        bit a;
        int k;
        if (!rst_n) begin
            m_perm = 0; m_rev = 0; m_pend = 0; m_bytes = 0;
            e_ackv = 0; e_ack = 0; e_we = 0; e_drop = 0;
        end else begin
            a = 0; k = 0;
            if (hdr_valid) begin
                if (hdr_class == 4'b1010) a = (hdr_sel == pin_addr);
                else if (hdr_class == 4'b0110 && m_perm == 0) begin
                    if (hv_a0) begin
                        if (hdr_sel == 3'b001 && pin_addr[2:1] == 2'b00) begin
                            a = (m_rev == 0); k = hdr_rd ? 0 : 2;
                        end else if (hdr_sel == 3'b011 && !hdr_rd && pin_addr[2:1] == 2'b01) begin
                            a = 1; k = 3;
                        end
                    end else if (hdr_sel == pin_addr) begin
                        a = 1; k = hdr_rd ? 0 : 1;
                    end
                end
                m_pend = a ? k : 0;
                m_bytes = 0;
            end else if (stop_det) begin
                if (m_pend != 0 && m_bytes >= 2 && !hw_wp) begin
                    if (m_pend == 1) m_perm = 1;
                    if (m_pend == 2) m_rev = 1;
                    if (m_pend == 3) m_rev = 0;
                end
                m_pend = 0; m_bytes = 0;
            end else if (byte_rx) m_bytes++;
            if (nv_load) m_perm = nv_perm;
            e_ackv = hdr_valid;
            e_ack  = hdr_valid && a;
            e_we   = wr_req && !(hw_wp || ((m_perm != 0 || m_rev != 0) && wr_addr < 8'h80));
            e_drop = wr_req && !e_we;
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        n_vec++;
        if ({ack_vld, ack, byte_we, byte_drop} !== {e_ackv, e_ack, e_we, e_drop}) begin
            n_bad++;
            $display("FAIL %s model act=%b%b%b%b exp=%b%b%b%b", cur_req,
                     ack_vld, ack, byte_we, byte_drop, e_ackv, e_ack, e_we, e_drop);
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hdr(input logic [3:0] c, input logic [2:0] s, input logic rd);
        @(negedge clk);
        hdr_valid = 1; hdr_class = c; hdr_sel = s; hdr_rd = rd;
        @(negedge clk);
        hdr_valid = 0;
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_rx = 1;
            @(negedge clk); byte_rx = 0;
        end
    endtask

    task automatic stop();
        @(negedge clk); stop_det = 1;
        @(negedge clk); stop_det = 0;
    endtask

    task automatic commit(input logic [7:0] a);
        @(negedge clk); wr_req = 1; wr_addr = a;
        @(negedge clk); wr_req = 0;
    endtask

    task automatic guard_cmd(input logic [2:0] s);
        hdr(4'b0110, s, 1'b0); bytes(2); stop();
    endtask

    initial begin
        #(8ns * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        cur_req = "R11";
        check("R11 reset ack_vld", ack_vld, 1'b0);
        check("R11 reset byte_we", byte_we, 1'b0);
        rst_n = 1;
        idle(1);

        cur_req = "R1";
        pin_addr = 3'b000;
        hdr(4'b1010, 3'b000, 1'b0); check("R1 match ack", ack, 1'b1);
        check("R1 ack_vld", ack_vld, 1'b1);
        hdr(4'b1010, 3'b100, 1'b1); check("R1 mismatch nack", ack, 1'b0);
        hdr(4'b1111, 3'b000, 1'b0); check("R1 foreign class nack", ack, 1'b0);

        cur_req = "R3";
        commit(8'h10); check("R3 open low write", byte_we, 1'b1);
        commit(8'h90); check("R3 open high write", byte_we, 1'b1);

        cur_req = "R6";
        hv_a0 = 1;
        guard_cmd(3'b001);
        cur_req = "R3";
        commit(8'h7F); check("R3 rev guards 0x7F", byte_we, 1'b0);
        cur_req = "R4";
        check("R4 drop flagged", byte_drop, 1'b1);
        cur_req = "R3";
        commit(8'h80); check("R3 0x80 open", byte_we, 1'b1);

        cur_req = "R7";
        hdr(4'b0110, 3'b001, 1'b1); check("R7 rev status set nack", ack, 1'b0);
        cur_req = "R8";
        hdr(4'b0110, 3'b001, 1'b0); check("R8 set rev again nack", ack, 1'b0);

        cur_req = "R10";
        pin_addr = 3'b010;
        hdr(4'b0110, 3'b011, 1'b0); check("R10 clr ack", ack, 1'b1);
        bytes(1); stop();
        hdr(4'b0110, 3'b011, 1'b0); bytes(1);
        hdr(4'b1010, 3'b010, 1'b1); bytes(2); stop();
        commit(8'h05); check("R10 aborted clear keeps guard", byte_we, 1'b0);
        cur_req = "R6";
        guard_cmd(3'b011);
        commit(8'h05); check("R6 cleared rev opens low half", byte_we, 1'b1);
        pin_addr = 3'b000;
        cur_req = "R7";
        hdr(4'b0110, 3'b001, 1'b1); check("R7 rev status clear ack", ack, 1'b1);

        cur_req = "R9";
        hv_a0 = 0;
        hdr(4'b0110, 3'b001, 1'b0); check("R9 set rev without hv nack", ack, 1'b0);
        pin_addr = 3'b010;
        hdr(4'b0110, 3'b011, 1'b0); check("R9 clr rev without hv nack", ack, 1'b0);

        cur_req = "R2";
        hw_wp = 1; hv_a0 = 1; pin_addr = 3'b000;
        commit(8'hC0); check("R2 hw blocks high", byte_we, 1'b0);
        hdr(4'b1010, 3'b000, 1'b1); check("R2 read still acks", ack, 1'b1);
        guard_cmd(3'b001);
        hw_wp = 0;
        hdr(4'b0110, 3'b001, 1'b1); check("R2 flag unchanged under hw", ack, 1'b1);

        cur_req = "R5";
        hv_a0 = 0; pin_addr = 3'b101;
        hdr(4'b0110, 3'b101, 1'b1); check("R5 perm status clear ack", ack, 1'b1);
        guard_cmd(3'b101);
        hdr(4'b0110, 3'b101, 1'b1); check("R5 perm status set nack", ack, 1'b0);
        hdr(4'b0110, 3'b101, 1'b0); check("R5 guard silenced", ack, 1'b0);
        hdr(4'b1010, 3'b101, 1'b0); check("R5 array still acks", ack, 1'b1);
        commit(8'h20); check("R5 perm guards low", byte_we, 1'b0);
        commit(8'hA0); check("R5 high open", byte_we, 1'b1);
        cur_req = "R8";
        hv_a0 = 1; pin_addr = 3'b010;
        hdr(4'b0110, 3'b011, 1'b0); check("R8 clr refused under perm", ack, 1'b0);

        cur_req = "R11";
        hv_a0 = 0;
        @(negedge clk); nv_load = 1; nv_perm = 0;
        @(negedge clk); nv_load = 0;
        commit(8'h20); check("R11 load clear", byte_we, 1'b1);
        @(negedge clk); nv_load = 1; nv_perm = 1;
        @(negedge clk); nv_load = 0;
        commit(8'h20); check("R11 load set", byte_we, 1'b0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        commit(8'h20); check("R11 reset clears flags", byte_we, 1'b1);

        idle(2);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule